// File: doc/BRIEF.md
# Wake-Input Level Monitor

This block watches four external wake pins while the chip sits in a low-power mode and reports them through a 4-bit status word. The pins are split into two pairs. Each pair has its own 2-bit sensitivity setting, held in a 4-bit control register. In Sleep or Stop, a pin that meets its pair's level condition latches its own status bit. That bit names the pin as the wake source. On the same cycle the block raises a one-clock wake request for the mode controller.

The status word has two roles. After a wake-up, the first read returns the latched source bits and then empties them. Every later read returns the live, synchronized level of each pin, with 1 meaning high. A watchdog timeout that comes before that first read discards the latched bits, but only if the wake-up came out of Stop. A wake from Sleep keeps its bits until they are read.

The asynchronous active-low reset is released through a two-flop synchronizer, so the block leaves reset on the third rising clock edge after `rst_n` goes high.

Top module: `wake_input_monitor`

## Requirements
- R1: Pins 0 and 1 use control bits 1:0, and pins 2 and 3 use control bits 3:2. Each 2-bit setting decodes as follows: 00 means the pair is off, 01 wakes on a high level, 10 wakes on a low level, and 11 wakes on either level.
- R2: A pin whose pair setting is 00 never sets a status bit and never causes a wake request.
- R3: In Sleep (`pmode_i`=10) or Stop (11), a qualifying pin sets its status bit three rising edges after it changes at the pin: two synchronizer stages plus the latch. Pins that qualify on the same cycle latch together.
- R4: `wake_req_o` is high for exactly one clock, in the cycle in which one or more status bits newly appear.
- R5: In Normal (00) or Standby (01), no status bit is newly set. Read data after the first read shows each pin's live synchronized level in bit position i for pin i.
- R6: A read-done flag selects the read data. While the flag is clear, `rd_data_o` shows the latched bits. A cycle with `rd_stb_i` high sets the flag, and if the flag was clear that read also empties the latched bits. While the flag is set, `rd_data_o` shows the live levels.
- R7: Each new wake event clears the read-done flag, so the next read again returns latched source bits.
- R8: If the last wake event happened in Stop, `wdt_to_i` high while the read-done flag is clear empties all four latched bits.
- R9: `wdt_to_i` leaves latched bits unchanged when the last wake event happened in Sleep. It also leaves them unchanged after the first read.
- R10: Reset clears the control register to 0000, the latched bits, the read-done flag and `wake_req_o`, so `rd_data_o` reads 0000.
- R11: A control write with `cfg_we_i` high loads `cfg_wdata_i` at that rising edge. The new setting governs qualification from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wake_pin_i | input | 4 | Asynchronous wake pins |
| pmode_i | input | 2 | Power mode: 00 Normal, 01 Standby, 10 Sleep, 11 Stop |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 4 | Control register write data, two bits per pin pair |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| rd_data_o | output | 4 | Status data: latched sources or live pin levels |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| wake_req_o | output | 1 | One-clock wake request |

## Verification
The hardest case to reach from the ports is a watchdog clear that depends on where the wake-up came from. The bench must first set up a wake in Stop, then return to Normal without reading, then pulse the timeout. It must then repeat the same pattern after a Sleep wake and after a read, so that the Stop clear can be told apart from the cases that keep the bits. Latched contents are only visible while the read-done flag is clear. For that reason, every scenario ends in a read that compares the first returned word with the pins that should have latched. It then follows with a second read that must show live levels. A behavioural model runs beside the design every cycle, including the reset synchronizer's delay, so that each wake pulse and each read word is compared on the exact cycle.

// File: rtl/wake_mon_pkg.sv
package wake_mon_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_STOP    = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;

  function automatic logic is_low_power(input pmode_e m);
    return (m == PM_SLEEP) || (m == PM_STOP);
  endfunction

endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= chain_d[s];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/wake_level_qual.sv
module wake_level_qual
  import wake_mon_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int GROUP  = 2
) (
  input  logic [N_PINS-1:0]                  level_i,
  input  logic [SENSE_W*(N_PINS/GROUP)-1:0]  cfg_i,
  output logic [N_PINS-1:0]                  hit_o
);

  localparam int N_GRP = N_PINS / GROUP;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    sense_e grp_sense;
    assign grp_sense = sense_e'(cfg_i[SENSE_W*g +: SENSE_W]);

    for (genvar p = 0; p < GROUP; p++) begin : g_pin
      localparam int IDX = g * GROUP + p;
      logic pin_hit;

      always_comb begin
        unique case (grp_sense)
          SENSE_HIGH: pin_hit = level_i[IDX];
          SENSE_LOW:  pin_hit = ~level_i[IDX];
          SENSE_ANY:  pin_hit = 1'b1;
          default:    pin_hit = 1'b0;
        endcase
      end

      assign hit_o[IDX] = pin_hit;
    end
  end

endmodule

// File: rtl/wake_src_latch.sv
module wake_src_latch #(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] hit_i,
  input  logic [N_PINS-1:0] level_i,
  input  logic              low_power_i,
  input  logic              in_stop_i,
  input  logic              rd_stb_i,
  input  logic              wdt_to_i,
  output logic [N_PINS-1:0] rd_data_o,
  output logic              wake_req_o
);

  logic [N_PINS-1:0] src_q, src_d;
  logic              seen_q, seen_d;
  logic              stop_q, stop_d;
  logic              req_q, req_d;

  logic [N_PINS-1:0] fresh;
  logic              first_rd;
  logic              wdt_clr;
  logic              src_en;
  logic              seen_en;

  always_comb begin
    fresh    = low_power_i ? (hit_i & ~src_q) : '0;
    first_rd = rd_stb_i & ~seen_q;
    wdt_clr  = wdt_to_i & stop_q & ~seen_q;
    req_d    = |fresh;
    src_en   = first_rd | wdt_clr | req_d;
    src_d    = ((first_rd | wdt_clr) ? '0 : src_q) | fresh;
    seen_en  = req_d | rd_stb_i;
    seen_d   = req_d ? 1'b0 : 1'b1;
    stop_d   = in_stop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      seen_q <= 1'b0;
      stop_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (src_en)  src_q  <= src_d;
      if (seen_en) seen_q <= seen_d;
      if (req_d)   stop_q <= stop_d;
    end
  end

  assign rd_data_o  = seen_q ? level_i : src_q;
  assign wake_req_o = req_q;

  // R5: nothing new latches while awake
  a_r5_no_latch_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power_i |=> ((src_q & ~$past(src_q)) == '0));

  // R4: a request always comes with fresh source bits
  a_r4_req_has_src: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> (src_q != '0));

  // R7: a new event leaves the read-done flag clear
  a_r7_event_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> !seen_q);

  // R8: stop-origin timeout before the first read empties the sources
  a_r8_stop_wdt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_to_i && stop_q && !seen_q && !low_power_i) |=> (src_q == '0));

  // R9: sleep-origin timeout keeps every latched bit
  a_r9_sleep_wdt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_to_i && !stop_q && !rd_stb_i) |=> (($past(src_q) & ~src_q) == '0));

  // R6: a read while awake leaves the flag set
  a_r6_read_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !low_power_i) |=> seen_q);

endmodule

// File: rtl/wake_input_monitor.sv
module wake_input_monitor
  import wake_mon_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int GROUP       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_PINS-1:0]                    wake_pin_i,
  input  logic [1:0]                           pmode_i,
  input  logic                                 cfg_we_i,
  input  logic [SENSE_W*(N_PINS/GROUP)-1:0]    cfg_wdata_i,
  input  logic                                 rd_stb_i,
  output logic [N_PINS-1:0]                    rd_data_o,
  input  logic                                 wdt_to_i,
  output logic                                 wake_req_o
);

  localparam int CFG_W     = SENSE_W * (N_PINS / GROUP);
  localparam int RST_STAGE = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGE-1:0] rst_sync_q;
  logic                 rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGE-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGE-1];

  // control register
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_we_i ? cfg_wdata_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  // mode decode
  pmode_e mode_w;
  logic   low_power;
  logic   in_stop;

  assign mode_w    = pmode_e'(pmode_i);
  assign low_power = is_low_power(mode_w);
  assign in_stop   = (mode_w == PM_STOP);

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] pin_hit;

  wake_pin_sync #(
    .W      (N_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (wake_pin_i),
    .sync_o  (pin_sync)
  );

  wake_level_qual #(
    .N_PINS (N_PINS),
    .GROUP  (GROUP)
  ) u_qual (
    .level_i (pin_sync),
    .cfg_i   (cfg_q),
    .hit_o   (pin_hit)
  );

  wake_src_latch #(
    .N_PINS (N_PINS)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .hit_i       (pin_hit),
    .level_i     (pin_sync),
    .low_power_i (low_power),
    .in_stop_i   (in_stop),
    .rd_stb_i    (rd_stb_i),
    .wdt_to_i    (wdt_to_i),
    .rd_data_o   (rd_data_o),
    .wake_req_o  (wake_req_o)
  );

  // R2: with every pair off, no request can follow
  a_r2_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_q == '0) |=> !wake_req_o);

  // R11: a write lands in the control register at that edge
  a_r11_cfg_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_we_i |=> (cfg_q == $past(cfg_wdata_i)));

endmodule

// File: tb/test_wake_input_monitor.sv
module test_wake_input_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic [3:0] wake_pin_i;
  logic [1:0] pmode_i;
  logic       cfg_we_i;
  logic [3:0] cfg_wdata_i;
  logic       rd_stb_i;
  logic [3:0] rd_data_o;
  logic       wdt_to_i;
  logic       wake_req_o;

  int compared   = 0;
  int mismatched = 0;
  int req_cnt    = 0;
  int cyc_cnt    = 0;
  bit cmp_on     = 0;

  wake_input_monitor i_wake_input_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_pin_i  (wake_pin_i),
    .pmode_i     (pmode_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .rd_stb_i    (rd_stb_i),
    .rd_data_o   (rd_data_o),
    .wdt_to_i    (wdt_to_i),
    .wake_req_o  (wake_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [3:0] m_s1, m_s2, m_cfg, m_lat;
  bit         m_seen, m_stop, m_req;
  int         m_rcnt;

  function automatic bit qualifies(input logic [1:0] sense, input logic lvl);
    case (sense)
      2'b01:   return lvl;
      2'b10:   return !lvl;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cfg = 0; m_lat = 0;
      m_seen = 0; m_stop = 0; m_req = 0; m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      bit         asleep;
      bit         clear;
      logic [3:0] newbits;
      asleep  = (pmode_i == 2'b10) || (pmode_i == 2'b11);
      newbits = 0;
      for (int i = 0; i < 4; i++) begin
        if (asleep && !m_lat[i] && qualifies(m_cfg[(i/2)*2 +: 2], m_s2[i]))
          newbits[i] = 1'b1;
      end
      clear = (rd_stb_i && !m_seen) || (wdt_to_i && m_stop && !m_seen);
      if (clear) m_lat = 0;
      m_lat = m_lat | newbits;
      m_req = (newbits != 0);
      if (m_req) begin
        m_seen = 0;
        m_stop = (pmode_i == 2'b11);
      end else if (rd_stb_i) begin
        m_seen = 1;
      end
      if (cfg_we_i) m_cfg = cfg_wdata_i;
      m_s2 = m_s1;
      m_s1 = wake_pin_i;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [3:0] exp_rd;
      exp_rd = m_seen ? m_s2 : m_lat;
      compared++;
      if (rd_data_o !== exp_rd) begin
        mismatched++;
        $display("FAIL R6 rd_data_o act %b exp %b at %0t", rd_data_o, exp_rd, $time);
      end
      compared++;
      if (wake_req_o !== m_req) begin
        mismatched++;
        $display("FAIL R4 wake_req_o act %b exp %b at %0t", wake_req_o, m_req, $time);
      end
      if (wake_req_o === 1'b1) req_cnt++;
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired after %0d cycles", cyc_cnt);
      report();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act %b exp %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_read(output logic [3:0] v);
    v = rd_data_o;
    rd_stb_i = 1'b1;
    cyc();
    rd_stb_i = 1'b0;
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = v;
    cyc();
    cfg_we_i    = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_to_i = 1'b1;
    cyc();
    wdt_to_i = 1'b0;
  endtask

  // ---------------- directed scenarios ----------------
  initial begin
    logic [3:0] rv;
    int         base;
    rst_n = 1'b0; wake_pin_i = 0; pmode_i = 2'b00;
    cfg_we_i = 0; cfg_wdata_i = 0; rd_stb_i = 0; wdt_to_i = 0;
    cyc(2);
    cmp_on = 1;
    chk("R10 reset rd_data", rd_data_o, 4'b0000);
    chk("R10 reset wake_req", {3'b000, wake_pin_i[0] & 1'b0 | wake_req_o}, 4'b0000);
    rst_n = 1'b1;
    cyc(5);

    // R10/R5: after reset, first read yields empty sources, later reads live
    write_cfg(4'b0101);
    wake_pin_i = 4'b1010;
    cyc(4);
    do_read(rv); chk("R10 first read empty", rv, 4'b0000);
    do_read(rv); chk("R5 live level", rv, 4'b1010);
    wake_pin_i = 4'b0101;
    cyc(3);
    do_read(rv); chk("R5 live follows pins", rv, 4'b0101);

    // R2/R3/R4: pair 1 off, pair 0 high-level, Sleep
    write_cfg(4'b0001);
    wake_pin_i = 4'b0000;
    cyc(3);
    pmode_i = 2'b10;
    base = req_cnt;
    wake_pin_i = 4'b1100;
    cyc(5);
    chk("R2 disabled pair no request", 4'(req_cnt - base), 4'd0);
    wake_pin_i = 4'b1110;
    cyc(5);
    chk("R4 single pulse", 4'(req_cnt - base), 4'd1);
    pmode_i = 2'b00;
    cyc();
    do_read(rv); chk("R3 latched source", rv, 4'b0010);
    cyc(2);
    do_read(rv); chk("R6 second read live", rv, 4'b1110);

    // R1/R3: pair 1 low-level, pair 0 either-level, simultaneous latch
    write_cfg(4'b1011);
    wake_pin_i = 4'b0100;
    cyc(3);
    base = req_cnt;
    pmode_i = 2'b10;
    cyc(4);
    chk("R3 simultaneous one pulse", 4'(req_cnt - base), 4'd1);
    pmode_i = 2'b00;
    cyc();
    do_read(rv); chk("R1 encodings latched", rv, 4'b1011);

    // R8: Stop wake, timeout before read clears
    write_cfg(4'b0001);
    wake_pin_i = 4'b0000;
    cyc(3);
    pmode_i = 2'b11;
    wake_pin_i = 4'b0001;
    cyc(5);
    pmode_i = 2'b00;
    cyc();
    pulse_wdt();
    do_read(rv); chk("R8 stop timeout cleared", rv, 4'b0000);
    do_read(rv); chk("R8 then live", rv, 4'b0001);

    // R9: Sleep wake, timeout keeps bits
    wake_pin_i = 4'b0000;
    cyc(3);
    pmode_i = 2'b10;
    wake_pin_i = 4'b0001;
    cyc(5);
    pmode_i = 2'b00;
    cyc();
    pulse_wdt();
    do_read(rv); chk("R9 sleep timeout kept", rv, 4'b0001);

    // R9: Stop wake, read first, then timeout: still live data
    wake_pin_i = 4'b0000;
    cyc(3);
    pmode_i = 2'b11;
    wake_pin_i = 4'b0001;
    cyc(5);
    pmode_i = 2'b00;
    cyc();
    do_read(rv); chk("R9 stop read before timeout", rv, 4'b0001);
    pulse_wdt();
    wake_pin_i = 4'b0000;
    cyc(3);
    do_read(rv); chk("R9 live after timeout", rv, 4'b0000);

    // R7: new wake after reads restores latched view
    write_cfg(4'b0100);
    cyc(2);
    pmode_i = 2'b10;
    wake_pin_i = 4'b1000;
    cyc(5);
    pmode_i = 2'b00;
    wake_pin_i = 4'b0000;
    cyc(3);
    do_read(rv); chk("R7 flag cleared by wake", rv, 4'b1000);

    // R11: control write enables an already-present level
    write_cfg(4'b0000);
    wake_pin_i = 4'b0001;
    pmode_i = 2'b10;
    cyc(4);
    base = req_cnt;
    write_cfg(4'b0001);
    cyc(2);
    chk("R11 write takes effect", 4'(req_cnt - base), 4'd1);
    pmode_i = 2'b00;
    cyc();
    do_read(rv); chk("R11 source after write", rv, 4'b0001);

    cyc(3);
    report();
  end

endmodule